// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts a single 128-bit plaintext block under a 128-bit key with the AES-128 cipher. It performs one cipher round per clock and derives each round key on the fly from the previous one, so no expanded key schedule is stored. A one-cycle load strobe starts an operation. A one-cycle done pulse marks the cycle in which the ciphertext output is valid.

The datapath holds one 128-bit state register and one 128-bit round-key register. The combinational round logic contains sixteen substitution units for the state and four for the key step. Each substitution unit computes the field inverse in a tower field, GF(2^4) squared, and then applies the affine transform, so no 256-entry table is used. The isomorphism matrices between the two field representations are derived at elaboration from the field polynomials. The core is used as a loosely coupled coprocessor: software or a controller places key and text on the inputs, pulses the strobe and collects the result when done is seen.

Top module: `aes_iter_core`

## Requirements
- R1: Byte k of a 128-bit word (k = 0..15) occupies bits [127-8k : 120-8k]. It maps to state row k mod 4 and column k div 4. Key, plaintext and ciphertext all follow this order.
- R2: An encryption is an initial key addition followed by ten rounds. Each round applies substitution, row rotation (row r rotated left by r bytes), column mixing and key addition, except that the tenth round omits column mixing. The known-answer vectors of the standard must be reproduced.
- R3: The substitution maps each byte to the affine transform (constant 0x63) of its inverse in GF(2^8) modulo x^8+x^4+x^3+x+1. The inverse of 0x00 is taken as 0x00. The all-zero key and all-zero plaintext therefore give 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R4: Round key n is derived from round key n-1 by rotating, substituting and adding a round constant to its last word. The constant starts at 0x01 and is doubled in the field every round. Nonzero keys must encrypt correctly.
- R5: When ld is high at a rising edge while the core is idle, the key and plaintext are captured at that edge. done is then high in the cycle after the tenth following rising edge.
- R6: done is high for exactly one cycle per accepted load.
- R7: ld is ignored while a block is being processed. Neither the result nor its timing changes.
- R8: While idle with ld low, ct_out holds the last ciphertext, whatever the key and plaintext inputs do. A new load may be accepted in the same cycle that done is high.
- R9: While rst_n is low, done is 0, ct_out is 0 and the core is idle, including when reset interrupts a block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld | input | 1 | Start strobe, honoured only while idle |
| key_in | input | 128 | Cipher key, byte 0 in the top bits |
| pt_in | input | 128 | Plaintext block, byte 0 in the top bits |
| ct_out | output | 128 | Ciphertext block, valid when done is high |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench builds the core with its default of ten rounds, the only count valid for a 128-bit key. With that count the standard known-answer vectors apply directly. One is the all-zero case, which drives 0x00 through every substitution unit in the first round. Others use nonzero keys, which exercise the full round-constant sequence. Fixing the round count also lets the bench count the exact latency, hit a load in the done cycle, fire a load in the middle of a block and apply a reset in the middle of a block.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BLK_W = 128;
  localparam int NBYTES = BLK_W / 8;

  typedef logic [7:0] byte_t;
  typedef logic [3:0] nib_t;

  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic byte_t gf8_mul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = xtime(t);
    end
    return acc;
  endfunction

  // GF(2^4) modulo x^4 + x + 1
  function automatic nib_t gf4_mul(nib_t a, nib_t b);
    nib_t acc = '0;
    nib_t t = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ t;
      t = {t[2:0], 1'b0} ^ (t[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic nib_t gf4_sq(nib_t a);
    return gf4_mul(a, a);
  endfunction

  // a^14 = a^-1 for a != 0, and 0 for a == 0
  function automatic nib_t gf4_inv(nib_t a);
    nib_t a2 = gf4_sq(a);
    nib_t a4 = gf4_sq(a2);
    nib_t a8 = gf4_sq(a4);
    return gf4_mul(gf4_mul(a8, a4), a2);
  endfunction

  // smallest v making y^2 + y + v irreducible over GF(2^4)
  function automatic nib_t find_lambda();
    nib_t res = '0;
    for (int v = 1; v < 16; v++) begin
      logic has_root = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((gf4_sq(nib_t'(t)) ^ nib_t'(t) ^ nib_t'(v)) == 4'h0) has_root = 1'b1;
      if (!has_root && res == 4'h0) res = nib_t'(v);
    end
    return res;
  endfunction

  localparam nib_t LAMBDA = find_lambda();

  // 8x8 bit matrix stored as eight byte columns
  function automatic byte_t lin_map(logic [63:0] m, byte_t x);
    byte_t acc = '0;
    for (int i = 0; i < 8; i++)
      if (x[i]) acc = acc ^ m[8*i +: 8];
    return acc;
  endfunction

  // composite {hi,lo} -> GF(2^8); columns are images of the tower basis
  function automatic logic [63:0] build_back();
    byte_t g = '0;
    byte_t y = '0;
    byte_t lam8 = '0;
    logic [31:0] pw;
    logic [63:0] m;
    for (int v = 2; v < 256; v++) begin
      byte_t b2 = gf8_mul(byte_t'(v), byte_t'(v));
      if ((gf8_mul(b2, b2) ^ byte_t'(v) ^ 8'h01) == 8'h00 && g == 8'h00) g = byte_t'(v);
    end
    pw[7:0]   = 8'h01;
    pw[15:8]  = g;
    pw[23:16] = gf8_mul(g, g);
    pw[31:24] = gf8_mul(pw[23:16], g);
    for (int j = 0; j < 4; j++)
      if (LAMBDA[j]) lam8 = lam8 ^ pw[8*j +: 8];
    for (int v = 2; v < 256; v++)
      if ((gf8_mul(byte_t'(v), byte_t'(v)) ^ byte_t'(v) ^ lam8) == 8'h00 && y == 8'h00)
        y = byte_t'(v);
    for (int j = 0; j < 4; j++) begin
      m[8*j +: 8]     = pw[8*j +: 8];
      m[8*(j+4) +: 8] = gf8_mul(pw[8*j +: 8], y);
    end
    return m;
  endfunction

  function automatic logic [63:0] build_fwd(logic [63:0] back);
    logic [63:0] f = '0;
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < 256; c++)
        if (lin_map(back, byte_t'(c)) == (8'h01 << i)) f[8*i +: 8] = byte_t'(c);
    return f;
  endfunction

  localparam logic [63:0] MAP_BACK = build_back();
  localparam logic [63:0] MAP_FWD  = build_fwd(MAP_BACK);

  function automatic byte_t affine(byte_t b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t blk_byte(logic [BLK_W-1:0] v, int k);
    return v[BLK_W-1-8*k -: 8];
  endfunction

  function automatic logic [BLK_W-1:0] rotate_rows(logic [BLK_W-1:0] v);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(4*c+r) -: 8] = blk_byte(v, 4*((c + r) % 4) + r);
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] mix_all(logic [BLK_W-1:0] v);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < 4; c++) begin
      byte_t a0 = blk_byte(v, 4*c);
      byte_t a1 = blk_byte(v, 4*c+1);
      byte_t a2 = blk_byte(v, 4*c+2);
      byte_t a3 = blk_byte(v, 4*c+3);
      o[BLK_W-1-8*(4*c)   -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      o[BLK_W-1-8*(4*c+1) -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      o[BLK_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      o[BLK_W-1-8*(4*c+3) -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return o;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  byte_t cf_val;
  nib_t  hi, lo;
  nib_t  norm, norm_inv;
  byte_t cf_inv;
  byte_t fld_inv;

  always_comb begin
    cf_val   = lin_map(MAP_FWD, din);
    hi       = cf_val[7:4];
    lo       = cf_val[3:0];
    norm     = gf4_mul(gf4_sq(hi), LAMBDA) ^ gf4_mul(hi, lo) ^ gf4_sq(lo);
    norm_inv = gf4_inv(norm);
    cf_inv   = {gf4_mul(hi, norm_inv), gf4_mul(hi ^ lo, norm_inv)};
    fld_inv  = lin_map(MAP_BACK, cf_inv);
    dout     = affine(fld_inv);
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] key_cur,
  input  byte_t            rcon,
  output logic [BLK_W-1:0] key_nxt
);
  logic [31:0] w0, w1, w2, w3, rot_w, sub_w, mix_w, n0, n1, n2, n3;

  assign w0    = key_cur[127:96];
  assign w1    = key_cur[95:64];
  assign w2    = key_cur[63:32];
  assign w3    = key_cur[31:0];
  assign rot_w = {w3[23:0], w3[31:24]};

  for (genvar k = 0; k < 4; k++) begin : g_sub
    aes_sbox u_sb (.din(rot_w[8*k +: 8]), .dout(sub_w[8*k +: 8]));
  end

  assign mix_w   = sub_w ^ {rcon, 24'h000000};
  assign n0      = w0 ^ mix_w;
  assign n1      = w1 ^ n0;
  assign n2      = w2 ^ n1;
  assign n3      = w3 ^ n2;
  assign key_nxt = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_pkg::*;
(
  input  logic [BLK_W-1:0] st_in,
  input  logic [BLK_W-1:0] rkey,
  input  logic             last,
  output logic [BLK_W-1:0] st_out
);
  logic [BLK_W-1:0] sub_st, rot_st, mix_st;

  for (genvar k = 0; k < NBYTES; k++) begin : g_sub
    aes_sbox u_sb (.din(st_in[8*k +: 8]), .dout(sub_st[8*k +: 8]));
  end

  assign rot_st = rotate_rows(sub_st);
  assign mix_st = mix_all(rot_st);
  assign st_out = (last ? rot_st : mix_st) ^ rkey;
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_pkg::*;
#(
  parameter int NUM_ROUNDS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [BLK_W-1:0] key_in,
  input  logic [BLK_W-1:0] pt_in,
  output logic [BLK_W-1:0] ct_out,
  output logic             done
);
  localparam int RC_W = $clog2(NUM_ROUNDS + 1);

  logic [BLK_W-1:0] state_q, rkey_q, key_nxt, round_out;
  byte_t            rcon_q;
  logic [RC_W-1:0]  round_q;
  logic             busy;
  logic             done_q;

  // named events, also observed by the bound checker
  logic start_evt, last_round, finish_evt;
  assign start_evt  = ld & ~busy;
  assign last_round = (round_q == RC_W'(NUM_ROUNDS));
  assign finish_evt = busy & last_round;

  aes_key_step u_key (.key_cur(rkey_q), .rcon(rcon_q), .key_nxt(key_nxt));
  aes_round    u_rnd (.st_in(state_q), .rkey(key_nxt), .last(last_round), .st_out(round_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      rkey_q  <= '0;
      rcon_q  <= '0;
      round_q <= '0;
      busy    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_evt;
      if (start_evt) begin
        state_q <= pt_in ^ key_in;
        rkey_q  <= key_in;
        rcon_q  <= 8'h01;
        round_q <= RC_W'(1);
        busy    <= 1'b1;
      end else if (busy) begin
        state_q <= round_out;
        rkey_q  <= key_nxt;
        rcon_q  <= xtime(rcon_q);
        round_q <= round_q + 1'b1;
        if (last_round) busy <= 1'b0;
      end
    end
  end

  assign ct_out = state_q;
  assign done   = done_q;
endmodule

// File: rtl/aes_iter_core_chk.sv
module aes_iter_core_chk #(
  parameter int NUM_ROUNDS = 10,
  localparam int RC_W = $clog2(NUM_ROUNDS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld,
  input logic            busy,
  input logic [RC_W-1:0] round_q,
  input logic            start_evt,
  input logic            finish_evt,
  input logic            done,
  input logic [127:0]    ct_out
);
  a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && round_q == RC_W'(1)));

  a_r5_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_busy_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish_evt) |=> (busy && round_q == $past(round_q) + 1'b1));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld) |=> $stable(ct_out));
endmodule

bind aes_iter_core aes_iter_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .busy(busy), .round_q(round_q),
  .start_evt(start_evt), .finish_evt(finish_evt), .done(done), .ct_out(ct_out)
);

// File: tb/aes_iter_core_test.sv
module aes_iter_core_test;
  logic         clk = 1'b0;
  logic         rst_n, ld, done;
  logic [127:0] key_in, pt_in, ct_out;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  aes_iter_core uut (.clk(clk), .rst_n(rst_n), .ld(ld), .key_in(key_in),
                     .pt_in(pt_in), .ct_out(ct_out), .done(done));

  localparam int NV = 5;
  // {key, plaintext, ciphertext}
  localparam logic [383:0] VEC [NV] = '{
    {128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e},
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h6bc1bee22e409f96e93d7e117393172a,
     128'h3ad77bb40d7a3660a89ecaf32466ef97},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hae2d8a571e03ac9c9eb76fac45af8e51,
     128'hf5d3d58503b9699de785895a96fdbaaf}
  };
  localparam string VREQ [NV] = '{"R3", "R1", "R2", "R4", "R4"};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // count cycles from the first negedge after the accepting edge until done
  task automatic wait_done(input bit keep_ld, output int lat);
    @(negedge clk);
    if (!keep_ld) ld = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [127:0] held;
    rst_n = 1'b0; ld = 1'b0; key_in = '0; pt_in = '0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R9", "done in reset", 128'(done), 128'h0);
    check(ct_out == '0, "R9", "ct in reset", ct_out, 128'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9", "done idle after reset", 128'(done), 128'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      key_in = VEC[i][383:256]; pt_in = VEC[i][255:128]; ld = 1'b1;
      wait_done(1'b0, lat);
      check(ct_out == VEC[i][127:0], VREQ[i], "ciphertext", ct_out, VEC[i][127:0]);
      check(lat == 10, "R5", "latency", 128'(lat), 128'd10);
      @(negedge clk);
      check(done == 1'b0, "R6", "done one cycle", 128'(done), 128'h0);
    end

    // R8: idle output holds while inputs move
    held = ct_out;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      key_in = {4{32'(j) * 32'h9e3779b9}};
      pt_in  = ~key_in;
      check(ct_out == held && done == 1'b0, "R8", "idle hold", ct_out, held);
    end

    // R7: ld asserted mid-block with other data
    @(negedge clk);
    key_in = VEC[2][383:256]; pt_in = VEC[2][255:128]; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0; lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    key_in = VEC[1][383:256]; pt_in = VEC[1][255:128]; ld = 1'b1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    ld = 1'b0;
    check(ct_out == VEC[2][127:0], "R7", "busy ld ignored result", ct_out, VEC[2][127:0]);
    check(lat == 10, "R7", "busy ld ignored timing", 128'(lat), 128'd10);
    @(negedge clk);
    check(ct_out == VEC[2][127:0] && done == 1'b0, "R8", "no late load", ct_out, VEC[2][127:0]);

    // R8: ld held high, reload accepted in the done cycle
    @(negedge clk);
    key_in = VEC[3][383:256]; pt_in = VEC[3][255:128]; ld = 1'b1;
    wait_done(1'b1, lat);
    check(ct_out == VEC[3][127:0] && lat == 10, "R8", "held ld first", ct_out, VEC[3][127:0]);
    key_in = VEC[0][383:256]; pt_in = VEC[0][255:128];
    wait_done(1'b0, lat);
    check(ct_out == VEC[0][127:0], "R8", "load in done cycle", ct_out, VEC[0][127:0]);
    check(lat == 10, "R8", "load in done cycle timing", 128'(lat), 128'd10);

    // R9: reset in the middle of a block
    @(negedge clk);
    key_in = VEC[1][383:256]; pt_in = VEC[1][255:128]; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ct_out == '0 && done == 1'b0, "R9", "mid-block reset", ct_out, 128'h0);
    rst_n = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (done) check(1'b0, "R9", "stray done after reset", 128'(done), 128'h0);
    end
    @(negedge clk);
    key_in = VEC[1][383:256]; pt_in = VEC[1][255:128]; ld = 1'b1;
    wait_done(1'b0, lat);
    check(ct_out == VEC[1][127:0] && lat == 10, "R9", "run after reset", ct_out, VEC[1][127:0]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule